// File: doc/BRIEF.md
# Element-Pointer Short Load/Store Unit

This unit executes the compact 16-bit load and store forms that address memory relative to a dedicated element-pointer register. An instruction is taken when the unit is idle. The unit decodes it and builds a displacement from the short field, scaled by the access size where the encoding calls for it and always zero-extended. It adds that displacement to the element pointer to form the address, then issues one byte, halfword or word access on a simple request/ready memory port.

For stores, the source value is copied across every lane of the write bus and the byte enables select the lanes that the size and the low address bits cover. For loads, the unit picks the addressed lane group out of the returned word and sign- or zero-extends it to 32 bits. It then writes the result to the destination register with a single-cycle strobe. Words that match none of the short forms are dropped.

Top module: `ep_short_lsu`

## Requirements
- R1: An instruction is accepted on a clock edge where `instr_valid` and `instr_ready` are both high. `mem_req` rises on the next cycle, and `mem_addr` equals `ep_value` plus the zero-extended displacement, with wrap-around modulo 2^32. `instr_ready` is low while a request is outstanding.
- R2: Encoding `instr[10:7]=0110` is a signed byte load with displacement `instr[6:0]`; the loaded byte is sign-extended.
- R3: Encoding `instr[10:4]=0000110` is an unsigned byte load with displacement `instr[3:0]`; the loaded byte is zero-extended.
- R4: Halfword loads: `instr[10:7]=1000` is signed with displacement `instr[6:0]*2`, and `instr[10:4]=0000111` is unsigned with displacement `instr[3:0]*2`.
- R5: `instr[10:7]=1010` is a word access with displacement `instr[6:1]*4`. `instr[0]=0` makes it a load and `instr[0]=1` makes it a store.
- R6: Stores are byte (`instr[10:7]=0111`, displacement `instr[6:0]`), halfword (`1001`, displacement `instr[6:0]*2`) and word (R5). Byte enables are `1<<addr[1:0]` for a byte, `0011` or `1100` by `addr[1]` for a halfword, and `1111` for a word. The write data repeats the low byte or halfword of `store_src` in every lane. A store never raises `rf_we`.
- R7: `mem_req`, `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` hold steady until an edge with `mem_ready` high. For a load, `rf_we` is high for exactly the one cycle after that edge, with `rf_waddr=instr[15:11]`. The byte at lane `addr[1:0]`, or the halfword at `addr[1]`, is taken little-endian from `mem_rdata`.
- R8: An accepted word that matches no listed form causes no memory request and no register write, and `instr_ready` stays high.
- R9: During and right after synchronous reset, `mem_req` and `rf_we` are low and `instr_ready` is high.
- R10: A new instruction can be accepted in the same cycle that the previous load's `rf_we` pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered |
| instr | input | 16 | Short load/store instruction word |
| ep_value | input | ADDR_W | Current element-pointer value |
| store_src | input | 32 | Register value to store |
| instr_ready | output | 1 | Unit idle, can take an instruction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of access |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, lane-replicated |
| mem_rdata | input | 32 | Read data from memory |
| mem_ready | input | 1 | Access completes this edge |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Destination register index |
| rf_wdata | output | 32 | Extended load result |

## Verification
The load write-back of one instruction and the acceptance of the next can occur in the same cycle. The bench provokes this by issuing loads back to back with zero-wait memory responses, so that the driver offers the next word exactly while `rf_wdata` is presented. A scoreboard then compares both the write-back value of the first load and the address and lanes of the second access against independently computed expectations. It also counts the overlapping cycles and requires at least one.

// File: rtl/ep_lsu_pkg.sv
package ep_lsu_pkg;

    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / 8;
    localparam int REG_IDX_W = 5;
    localparam int DISP_W    = 8;
    localparam int INSN_W    = 16;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

    // decoded view of one short instruction
    typedef struct packed {
        logic                 hit;
        logic                 store;
        logic                 sext;
        acc_size_e            size;
        logic [DISP_W-1:0]    disp;
        logic [REG_IDX_W-1:0] rd;
    } sop_t;

    // control kept while an access is outstanding
    typedef struct packed {
        logic                 store;
        logic                 sext;
        acc_size_e            size;
        logic [1:0]           lo;
        logic [REG_IDX_W-1:0] rd;
    } pend_ctl_t;

    function automatic logic [LANES-1:0] lane_enables(acc_size_e sz, logic [1:0] lo);
        logic [LANES-1:0] m;
        case (sz)
            ACC_BYTE: m = LANES'(1) << lo;
            ACC_HALF: m = lo[1] ? LANES'(4'b1100) : LANES'(4'b0011);
            default:  m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ep_lsu_decode.sv
module ep_lsu_decode
    import ep_lsu_pkg::*;
(
    input  logic [INSN_W-1:0] ins,
    output sop_t              op
);
    always_comb begin
        op       = '0;
        op.size  = ACC_BYTE;
        op.rd    = ins[15:11];
        case (ins[10:7])
            4'b0110: begin
                op.hit  = 1'b1;
                op.sext = 1'b1;
                op.disp = {1'b0, ins[6:0]};
            end
            4'b0111: begin
                op.hit   = 1'b1;
                op.store = 1'b1;
                op.disp  = {1'b0, ins[6:0]};
            end
            4'b1000: begin
                op.hit  = 1'b1;
                op.sext = 1'b1;
                op.size = ACC_HALF;
                op.disp = {ins[6:0], 1'b0};
            end
            4'b1001: begin
                op.hit   = 1'b1;
                op.store = 1'b1;
                op.size  = ACC_HALF;
                op.disp  = {ins[6:0], 1'b0};
            end
            4'b1010: begin
                op.hit   = 1'b1;
                op.store = ins[0];
                op.size  = ACC_WORD;
                op.disp  = {ins[6:1], 2'b00};
            end
            4'b0000: begin
                if (ins[6:4] == 3'b110) begin
                    op.hit  = 1'b1;
                    op.disp = {4'b0000, ins[3:0]};
                end else if (ins[6:4] == 3'b111) begin
                    op.hit  = 1'b1;
                    op.size = ACC_HALF;
                    op.disp = {3'b000, ins[3:0], 1'b0};
                end
            end
            default: op.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ep_lsu_store_lanes.sv
module ep_lsu_store_lanes
    import ep_lsu_pkg::*;
(
    input  acc_size_e         size,
    input  logic [1:0]        lo,
    input  logic [WORD_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] wdata
);
    assign be = lane_enables(size, lo);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            case (size)
                ACC_BYTE: wdata[8*g +: 8] = src[7:0];
                ACC_HALF: wdata[8*g +: 8] = src[8*(g%2) +: 8];
                default:  wdata[8*g +: 8] = src[8*g +: 8];
            endcase
        end
    end
endmodule

// File: rtl/ep_lsu_load_extend.sv
module ep_lsu_load_extend
    import ep_lsu_pkg::*;
(
    input  acc_size_e         size,
    input  logic              sext,
    input  logic [1:0]        lo,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] value
);
    logic [7:0]  lane [LANES];
    logic [7:0]  pick_b;
    logic [15:0] pick_h;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane[g] = rdata[8*g +: 8];
    end

    assign pick_b = lane[lo];
    assign pick_h = {lane[{lo[1], 1'b1}], lane[{lo[1], 1'b0}]};

    always_comb begin
        case (size)
            ACC_BYTE: value = {{(WORD_W-8){sext & pick_b[7]}}, pick_b};
            ACC_HALF: value = {{(WORD_W-16){sext & pick_h[15]}}, pick_h};
            default:  value = rdata;
        endcase
    end
endmodule

// File: rtl/ep_short_lsu.sv
module ep_short_lsu
    import ep_lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_valid,
    input  logic [INSN_W-1:0]    instr,
    input  logic [ADDR_W-1:0]    ep_value,
    input  logic [WORD_W-1:0]    store_src,
    output logic                 instr_ready,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LANES-1:0]     mem_be,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [WORD_W-1:0]    rf_wdata
);
    typedef enum logic {S_IDLE, S_BUSY} lsu_state_e;

    lsu_state_e         state_q;
    sop_t               dec;
    logic [ADDR_W-1:0]  addr_n;
    logic [LANES-1:0]   be_n;
    logic [WORD_W-1:0]  wdata_n;
    logic [WORD_W-1:0]  load_val;

    logic [ADDR_W-1:0]    addr_q;
    logic [LANES-1:0]     be_q;
    logic [WORD_W-1:0]    wdata_q;
    pend_ctl_t            ctl_q;
    logic                 wb_q;
    logic [REG_IDX_W-1:0] wb_idx_q;
    logic [WORD_W-1:0]    wb_val_q;

    ep_lsu_decode u_dec (
        .ins (instr),
        .op  (dec)
    );

    assign addr_n = ep_value + ADDR_W'(dec.disp);

    ep_lsu_store_lanes u_st (
        .size  (dec.size),
        .lo    (addr_n[1:0]),
        .src   (store_src),
        .be    (be_n),
        .wdata (wdata_n)
    );

    ep_lsu_load_extend u_ld (
        .size  (ctl_q.size),
        .sext  (ctl_q.sext),
        .lo    (ctl_q.lo),
        .rdata (mem_rdata),
        .value (load_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            addr_q   <= '0;
            be_q     <= '0;
            wdata_q  <= '0;
            ctl_q    <= '0;
            wb_q     <= 1'b0;
            wb_idx_q <= '0;
            wb_val_q <= '0;
        end else begin
            wb_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (instr_valid && dec.hit) begin
                        addr_q      <= addr_n;
                        be_q        <= be_n;
                        wdata_q     <= wdata_n;
                        ctl_q.store <= dec.store;
                        ctl_q.sext  <= dec.sext;
                        ctl_q.size  <= dec.size;
                        ctl_q.lo    <= addr_n[1:0];
                        ctl_q.rd    <= dec.rd;
                        state_q     <= S_BUSY;
                    end
                end
                default: begin
                    if (mem_ready) begin
                        state_q <= S_IDLE;
                        if (!ctl_q.store) begin
                            wb_q     <= 1'b1;
                            wb_idx_q <= ctl_q.rd;
                            wb_val_q <= load_val;
                        end
                    end
                end
            endcase
        end
    end

    assign instr_ready = (state_q == S_IDLE);
    assign mem_req     = (state_q == S_BUSY);
    assign mem_we      = ctl_q.store;
    assign mem_addr    = addr_q;
    assign mem_be      = be_q;
    assign mem_wdata   = wdata_q;
    assign rf_we       = wb_q;
    assign rf_waddr    = wb_idx_q;
    assign rf_wdata    = wb_val_q;
endmodule

// File: rtl/ep_lsu_chk.sv
module ep_lsu_chk
    import ep_lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_be,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              rf_we
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !instr_ready); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_be) && $stable(mem_wdata))); // R7

    AST_WB_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && !mem_we) |=> rf_we); // R7

    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we); // R7

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && mem_we) |=> !rf_we); // R6

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b0011
                     || mem_be == 4'b1100 || mem_be == 4'b1111)); // R6

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mem_req && !rf_we && instr_ready)); // R9
endmodule

bind ep_short_lsu ep_lsu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_ready (instr_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .rf_we       (rf_we)
);

// File: tb/sim_ep_short_lsu.sv
`timescale 1ns/1ps
module sim_ep_short_lsu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] ep_value = '0;
    logic [31:0] store_src = '0;
    logic        instr_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;

    int total = 0;
    int bad = 0;
    int overlap = 0;

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [3:0]  be;
        logic [31:0] wd;
        string       tag;
    } acc_t;
    typedef struct {
        logic [4:0]  idx;
        logic [31:0] val;
        string       tag;
    } wb_t;
    typedef struct {
        int          dly;
        logic [31:0] rd;
    } rsp_t;

    acc_t exp_acc[$];
    wb_t  exp_wb[$];
    rsp_t rsp_q[$];

    always #2 clk = ~clk;

    ep_short_lsu u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .ep_value(ep_value), .store_src(store_src), .instr_ready(instr_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: builds expectations from the requirement text, then offers the word
    task automatic issue(input logic [15:0] ins, input logic [31:0] epv,
                         input logic [31:0] st, input logic [31:0] rd, input int dly);
        logic [7:0]  d = '0;
        int          sz = -1;      // 0 byte, 1 half, 2 word
        bit          store = 0, sx = 0;
        string       tag = "R8";
        logic [31:0] a, v;
        logic [1:0]  lo;
        acc_t        ea;
        wb_t         ew;
        casez (ins[10:0])
            11'b0110???????: begin sz = 0; sx = 1; d = {1'b0, ins[6:0]}; tag = "R2"; end
            11'b0000110????: begin sz = 0; d = {4'b0, ins[3:0]}; tag = "R3"; end
            11'b1000???????: begin sz = 1; sx = 1; d = {ins[6:0], 1'b0}; tag = "R4"; end
            11'b0000111????: begin sz = 1; d = {3'b0, ins[3:0], 1'b0}; tag = "R4"; end
            11'b1010??????0: begin sz = 2; d = {ins[6:1], 2'b0}; tag = "R5"; end
            11'b1010??????1: begin sz = 2; store = 1; d = {ins[6:1], 2'b0}; tag = "R5"; end
            11'b0111???????: begin sz = 0; store = 1; d = {1'b0, ins[6:0]}; tag = "R6"; end
            11'b1001???????: begin sz = 1; store = 1; d = {ins[6:0], 1'b0}; tag = "R6"; end
            default: sz = -1;
        endcase
        if (sz >= 0) begin
            a  = epv + {24'b0, d};
            lo = a[1:0];
            ea.addr = a; ea.we = store; ea.tag = tag;
            if (sz == 0) begin
                ea.be = 4'b0001 << lo; ea.wd = {4{st[7:0]}};
                v = (rd >> (8 * lo)) & 32'hFF;
                if (sx && v[7]) v = v | 32'hFFFF_FF00;
            end else if (sz == 1) begin
                ea.be = lo[1] ? 4'b1100 : 4'b0011; ea.wd = {2{st[15:0]}};
                v = (rd >> (16 * lo[1])) & 32'hFFFF;
                if (sx && v[15]) v = v | 32'hFFFF_0000;
            end else begin
                ea.be = 4'b1111; ea.wd = st; v = rd;
            end
            exp_acc.push_back(ea);
            rsp_q.push_back('{dly, rd});
            if (!store) begin
                ew.idx = ins[15:11]; ew.val = v; ew.tag = tag;
                exp_wb.push_back(ew);
            end
        end
        while (!instr_ready) @(negedge clk);
        instr = ins; ep_value = epv; store_src = st; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // memory responder
    initial begin
        rsp_t cur;
        bit   have = 0;
        int   cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) mem_ready = 1'b0;
            else if (mem_req) begin
                if (!have) begin
                    if (rsp_q.size() == 0) begin
                        check(0, "R8 unexpected request", mem_addr, 32'h0);
                        cur = '{0, 32'h0};
                    end else cur = rsp_q.pop_front();
                    have = 1; cnt = 0;
                end
                if (cnt >= cur.dly) begin
                    mem_rdata = cur.rd; mem_ready = 1'b1; have = 0;
                end else cnt++;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        acc_t ea;
        wb_t  ew;
        forever begin
            @(negedge clk); #1;
            if (!rst) begin
                if (mem_req && mem_ready) begin
                    if (exp_acc.size() == 0) check(0, "R8 stray access", mem_addr, 32'h0);
                    else begin
                        ea = exp_acc.pop_front();
                        check(mem_addr == ea.addr, {ea.tag, " R1 address"}, mem_addr, ea.addr);
                        check(mem_we == ea.we, {ea.tag, " direction"}, {31'b0, mem_we}, {31'b0, ea.we});
                        check(mem_be == ea.be, {ea.tag, " R6 byte enables"}, {28'b0, mem_be}, {28'b0, ea.be});
                        if (ea.we) check(mem_wdata == ea.wd, {ea.tag, " R6 write data"}, mem_wdata, ea.wd);
                    end
                end
                if (rf_we) begin
                    if (instr_valid && instr_ready) overlap++;
                    if (exp_wb.size() == 0) check(0, "R6 write without load", {27'b0, rf_waddr}, 32'h0);
                    else begin
                        ew = exp_wb.pop_front();
                        check(rf_waddr == ew.idx, {ew.tag, " R7 dest index"}, {27'b0, rf_waddr}, {27'b0, ew.idx});
                        check(rf_wdata == ew.val, {ew.tag, " R7 load value"}, rf_wdata, ew.val);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        check(0, "watchdog", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(instr_ready == 1'b1, "R9 ready in reset", {31'b0, instr_ready}, 32'h1);
        rst = 1'b0;
        @(negedge clk);
        check(mem_req == 1'b0, "R9 mem_req after reset", {31'b0, mem_req}, 32'h0);
        check(rf_we == 1'b0, "R9 rf_we after reset", {31'b0, rf_we}, 32'h0);
        check(instr_ready == 1'b1, "R9 instr_ready after reset", {31'b0, instr_ready}, 32'h1);

        // R2 signed byte, negative, lane 3
        issue({5'd3, 4'b0110, 7'h05}, 32'h1000_0002, 32'h0, 32'h85AA_BBCC, 2);
        // R3 unsigned byte, lane 2
        issue({5'd7, 7'b0000110, 4'hD}, 32'h2000_0001, 32'h0, 32'h00F0_0000, 1);
        // R4 signed halfword, upper half
        issue({5'd9, 4'b1000, 7'h7F}, 32'h0000_0100, 32'h0, 32'h8001_1234, 0);
        // R4 unsigned halfword, scaled 4-bit field
        issue({5'd10, 7'b0000111, 4'hF}, 32'h0000_0040, 32'h0, 32'hBEEF_0000, 3);
        // R5 word load with address wrap
        issue({5'd12, 4'b1010, 6'h3F, 1'b0}, 32'hFFFF_FF04, 32'h0, 32'hCAFE_F00D, 1);
        // R6 stores
        issue({5'd1, 4'b0111, 7'h7F}, 32'h0000_0001, 32'h1234_5678, 32'h0, 0);
        issue({5'd2, 4'b1001, 7'h01}, 32'h0000_0010, 32'hAAAA_5678, 32'h0, 2);
        issue({5'd4, 4'b1010, 6'h01, 1'b1}, 32'h0000_0020, 32'hDEAD_BEEF, 32'h0, 1);
        // R2/R3 every lane
        for (int k = 0; k < 4; k++) begin
            issue({5'(k + 16), 4'b0110, 7'h00}, 32'h0000_0300 + k, 32'h0, 32'h80FF_7F01, k);
            issue({5'(k + 20), 7'b0000110, 4'h0}, 32'h0000_0400 + k, 32'h0, 32'h80FF_7F01, 0);
        end
        // R8 words outside the short forms
        issue({5'd5, 4'b1011, 7'h00}, 32'h0, 32'h0, 32'h0, 0);
        check(instr_ready == 1'b1 && mem_req == 1'b0, "R8 no request (a)", {31'b0, mem_req}, 32'h0);
        issue({5'd5, 7'b0000101, 4'h3}, 32'h0, 32'h0, 32'h0, 0);
        check(instr_ready == 1'b1 && mem_req == 1'b0, "R8 no request (b)", {31'b0, mem_req}, 32'h0);
        issue(16'hFFFF, 32'h0, 32'h0, 32'h0, 0);
        check(instr_ready == 1'b1 && mem_req == 1'b0, "R8 no request (c)", {31'b0, mem_req}, 32'h0);
        repeat (3) begin
            @(negedge clk);
            check(mem_req == 1'b0 && rf_we == 1'b0, "R8 quiet", {31'b0, mem_req | rf_we}, 32'h0);
        end
        // R10 back-to-back zero-wait loads
        for (int k = 0; k < 6; k++)
            issue({5'(k + 24), 4'b1010, 6'(k), 1'b0}, 32'h0000_1000, 32'h0, 32'h0101_0101 * (k + 1), 0);

        repeat (20) @(negedge clk);
        check(exp_acc.size() == 0, "R7 all accesses seen", exp_acc.size(), 32'h0);
        check(exp_wb.size() == 0, "R7 all writes seen", exp_wb.size(), 32'h0);
        check(overlap > 0, "R10 accept during write-back", overlap, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule